// File: doc/BRIEF.md
# Camera Link Frame Capture Front End

This block sits behind the deserialiser of one Camera Link Base port. On every pixel clock it sees 24 pixel bits together with the frame, line and data qualifiers and a spare bit. It decides which cycles carry pixels, groups them into lines and frames, and hands the pixels of captured frames to a downstream sink as a simple valid/data stream. The stream marks the first pixel of each frame and the last pixel of each line.

The block also keeps measuring the incoming image while capture is idle. It reports the pixel count of a line, the number of lines in a frame, and the number of complete frames seen in each one-second window. Software can then read the resolution back and set up capture to match it. Three controls drive the block: a master enable, a select that decides whether the data qualifier is used, and a start/stop toggle. Capture always begins on a frame boundary, so only whole frames reach the sink.

Top module: `cl_frame_capture`

## Requirements
- R1: With `cfg_dval_use` = 1 a cycle carries a pixel only when `in_fval`, `in_lval` and `in_dval` are all 1.
- R2: With `cfg_dval_use` = 0, `in_dval` has no effect: every cycle with `in_fval` = 1 and `in_lval` = 1 carries a pixel.
- R3: Each rising edge of `cap_start` flips the run state. Once running, capture starts at the next rising edge of `in_fval` that follows. A frame that is already under way when start arrives is skipped.
- R4: A stop that arrives during a captured frame lets that frame complete in full. No later frame is captured.
- R5: `out_sof` is 1 on the first delivered pixel of each captured frame. `out_eol` is 1 on the last accepted pixel of each line. Both are 0 on every other word.
- R6: If `out_ready` is 0 when a word is due, the word is dropped and `out_overflow` goes to 1. It stays at 1 until reset.
- R7: At each falling edge of `in_fval`, `stat_width` takes the accepted-pixel count of the last line of that frame and `stat_height` takes the number of lines in the frame. This happens whether or not capture is running.
- R8: `stat_fps` changes only at the end of each window of `SEC_CYCLES` clocks counted from reset. It then takes the number of `in_fval` falling edges seen in that window.
- R9: While `cfg_enable` = 0 nothing is delivered, the run state is cleared and `cap_start` is ignored. Measurement continues.
- R10: After reset `out_valid`, `out_overflow`, `stat_width`, `stat_height` and `stat_fps` are all 0. Capture is stopped.
- R11: Delivered words carry the accepted pixel bits unchanged and in arrival order. `in_spare` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Master enable |
| cfg_dval_use | input | 1 | 1: qualify pixels with the data-valid bit |
| cap_start | input | 1 | Start/stop toggle, acts on its rising edge |
| in_pix | input | PIX_W | Pixel bits |
| in_fval | input | 1 | Frame qualifier |
| in_lval | input | 1 | Line qualifier |
| in_dval | input | 1 | Data qualifier |
| in_spare | input | 1 | Spare bit, unused |
| out_ready | input | 1 | Sink can take a word |
| out_valid | output | 1 | Word present |
| out_data | output | PIX_W | Pixel bits |
| out_sof | output | 1 | First pixel of frame |
| out_eol | output | 1 | Last pixel of line |
| out_overflow | output | 1 | Sticky drop flag |
| stat_width | output | CNT_W | Measured pixels per line |
| stat_height | output | CNT_W | Measured lines per frame |
| stat_fps | output | CNT_W | Frames in last one-second window |

## Verification
Two situations are hard to reach: a start or stop pulse that lands in the middle of a frame, and a line whose last accepted pixel is followed by data-valid gaps before the line qualifier falls. The stimulus tackles the first with a frame driver that can raise `cap_start` at a chosen cycle inside the frame. It tackles the second with random data-valid gaps. A tight-timing frame variant raises the frame and line qualifiers together and drops them together, which exercises the end-of-line marker and the width latch on the same edge. Frame counts per window are checked by a bench model that counts qualifier falling edges against the cycle count since reset.

// File: rtl/cl_frame_capture.sv
module cl_frame_capture #(
  parameter int PIX_W      = 24,
  parameter int CNT_W      = 16,
  parameter int SEC_CYCLES = 85_000_000,
  localparam int SEC_W     = $clog2(SEC_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_dval_use,
  input  logic             cap_start,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_fval,
  input  logic             in_lval,
  input  logic             in_dval,
  input  logic             in_spare,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol,
  output logic             out_overflow,
  output logic [CNT_W-1:0] stat_width,
  output logic [CNT_W-1:0] stat_height,
  output logic [CNT_W-1:0] stat_fps
);

  logic spare_unused;
  assign spare_unused = in_spare;

  logic fval_q, line_q, start_q, run, frame_cap, first_flag;
  logic hold_vld, hold_sof;
  logic [PIX_W-1:0] hold_data;
  logic [CNT_W-1:0] pix_cnt, last_w, line_cnt, frame_cnt;
  logic [SEC_W-1:0] sec_cnt;

  logic line_on, acc, fval_rise, fval_fall, line_start, line_end;
  logic sec_tick, cap_now, take, emit;

  assign line_on    = in_fval & in_lval;
  assign acc        = line_on & (in_dval | ~cfg_dval_use);
  assign fval_rise  = in_fval & ~fval_q;
  assign fval_fall  = ~in_fval & fval_q;
  assign line_start = line_on & ~line_q;
  assign line_end   = ~line_on & line_q;
  assign sec_tick   = (sec_cnt == SEC_W'(SEC_CYCLES - 1));
  assign cap_now    = cfg_enable & (frame_cap | (fval_rise & run));
  assign take       = acc & cap_now;
  assign emit       = cfg_enable & hold_vld & (take | line_end);

  // capture path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q      <= 1'b0;
      run          <= 1'b0;
      frame_cap    <= 1'b0;
      first_flag   <= 1'b0;
      hold_vld     <= 1'b0;
      hold_sof     <= 1'b0;
      hold_data    <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sof      <= 1'b0;
      out_eol      <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      start_q <= cap_start;
      if (!cfg_enable) begin
        run        <= 1'b0;
        frame_cap  <= 1'b0;
        first_flag <= 1'b0;
        hold_vld   <= 1'b0;
      end else begin
        if (cap_start & ~start_q) run <= ~run;
        if (fval_rise & run)  frame_cap <= 1'b1;
        else if (fval_fall)   frame_cap <= 1'b0;
        if (take)                  first_flag <= 1'b0;
        else if (fval_rise & run)  first_flag <= 1'b1;
        if (take) begin
          hold_vld  <= 1'b1;
          hold_data <= in_pix;
          hold_sof  <= first_flag | fval_rise;
        end else if (line_end) begin
          hold_vld <= 1'b0;
        end
      end
      out_valid <= emit & out_ready;
      if (emit) begin
        out_data <= hold_data;
        out_sof  <= hold_sof;
        out_eol  <= line_end;
      end
      if (emit & ~out_ready) out_overflow <= 1'b1;
    end
  end

  // measurement path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fval_q      <= 1'b0;
      line_q      <= 1'b0;
      pix_cnt     <= '0;
      last_w      <= '0;
      line_cnt    <= '0;
      frame_cnt   <= '0;
      sec_cnt     <= '0;
      stat_width  <= '0;
      stat_height <= '0;
      stat_fps    <= '0;
    end else begin
      fval_q <= in_fval;
      line_q <= line_on;
      if (line_start)  pix_cnt <= CNT_W'(acc);
      else if (acc)    pix_cnt <= pix_cnt + 1'b1;
      if (line_end)    last_w <= pix_cnt;
      if (fval_rise)        line_cnt <= CNT_W'(line_start);
      else if (line_start)  line_cnt <= line_cnt + 1'b1;
      if (fval_fall) begin
        stat_width  <= line_end ? pix_cnt : last_w;
        stat_height <= line_cnt;
      end
      sec_cnt <= sec_tick ? '0 : sec_cnt + 1'b1;
      if (sec_tick) begin
        stat_fps  <= frame_cnt + CNT_W'(fval_fall);
        frame_cnt <= '0;
      end else if (fval_fall) begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_overflow |=> out_overflow);

  // R9
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(out_ready) && $past(cfg_enable)));

  // R7
  height_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_height) |-> $past(fval_q && !in_fval));

  // R7
  width_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_width) |-> $past(fval_q && !in_fval));

  // R8
  fps_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_fps) |-> $past(sec_tick));

endmodule

// File: tb/tb_cl_frame_capture.sv
module tb_cl_frame_capture;
  localparam int PW  = 24;
  localparam int CW  = 16;
  localparam int SEC = 1000;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_dval_use = 0, cap_start = 0;
  logic [PW-1:0] in_pix = '0;
  logic in_fval = 0, in_lval = 0, in_dval = 0, in_spare = 0, out_ready = 1;
  logic out_valid, out_sof, out_eol, out_overflow;
  logic [PW-1:0] out_data;
  logic [CW-1:0] stat_width, stat_height, stat_fps;

  always #5 clk = ~clk;

  cl_frame_capture #(.PIX_W(PW), .CNT_W(CW), .SEC_CYCLES(SEC)) dut (
    .clk, .rst_n, .cfg_enable, .cfg_dval_use, .cap_start, .in_pix, .in_fval,
    .in_lval, .in_dval, .in_spare, .out_ready, .out_valid, .out_data, .out_sof,
    .out_eol, .out_overflow, .stat_width, .stat_height, .stat_fps);

  int checks = 0, fails = 0, seen = 0, pushed = 0;
  bit done = 0, run_m = 0, cur_cap = 0, first_m = 0, line_pushed = 0;
  int cyc_n = 0, tog_at = -1, line_n = 0;
  logic [PW+1:0] expq[$];

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // stream collector
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      seen++;
      if (expq.size() == 0) check("R11", "unexpected word", 1, 0);
      else begin
        logic [PW+1:0] e;
        e = expq.pop_front();
        check("R11", "pixel data", out_data, e[PW-1:0]);
        check("R5", "sof flag", out_sof, e[PW+1]);
        check("R5", "eol flag", out_eol, e[PW]);
      end
    end
  end

  // frames-per-window model
  int cyc_b = 0, fc = 0, exp_fps = 0;
  bit prevf = 0, fps_due = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc_b = 0; fc = 0; prevf = 0;
    end else begin
      cyc_b++;
      if (cyc_b % SEC == 0) begin
        exp_fps = fc + int'(prevf && !in_fval);
        fc = 0;
        fps_due = 1;
      end else fc += int'(prevf && !in_fval);
      prevf = in_fval;
    end
  end
  always @(negedge clk) begin
    if (fps_due) begin
      fps_due = 0;
      check("R8", "frames per window", stat_fps, exp_fps);
    end
  end

  task automatic step(bit f, bit l, int dpct);
    @(negedge clk);
    in_fval  = f;
    in_lval  = l;
    in_dval  = ($urandom_range(99) < dpct);
    in_pix   = PW'($urandom);
    in_spare = 1'($urandom);
    cap_start = (cyc_n == tog_at);
    if (cyc_n == tog_at && cfg_enable) run_m = !run_m;
    cyc_n++;
    if (f && l && (in_dval || !cfg_dval_use)) begin
      line_n++;
      if (cur_cap && out_ready) begin
        expq.push_back({first_m, 1'b0, in_pix});
        pushed++;
        first_m = 0;
        line_pushed = 1;
      end
    end
  endtask

  task automatic frame(int w, int h, bit tight, int dp, int tog, string tag);
    int p0, s0;
    p0 = pushed; s0 = seen;
    cur_cap = run_m && cfg_enable;
    first_m = 1; cyc_n = 0; tog_at = tog;
    if (!tight) begin step(1, 0, dp); step(1, 0, dp); end
    for (int y = 0; y < h; y++) begin
      line_n = 0; line_pushed = 0;
      for (int x = 0; x < w; x++) step(1, 1, dp);
      if (line_pushed) expq[expq.size()-1][PW] = 1'b1;
      if (tight && y == h - 1) step(0, 0, dp);
      else begin step(1, 0, dp); step(1, 0, dp); end
    end
    if (!tight) step(0, 0, dp);
    step(0, 0, dp);
    check("R7", "width", stat_width, line_n);
    check("R7", "height", stat_height, h);
    step(0, 0, dp); step(0, 0, dp);
    check(tag, "words delivered", seen - s0, pushed - p0);
    check(tag, "pending words", expq.size(), 0);
  endtask

  task automatic pulse();
    @(negedge clk); cap_start = 1;
    if (cfg_enable) run_m = !run_m;
    @(negedge clk); cap_start = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10", "out_valid", out_valid, 0);
    check("R10", "overflow", out_overflow, 0);
    check("R10", "width", stat_width, 0);
    check("R10", "height", stat_height, 0);
    check("R10", "fps", stat_fps, 0);

    // measurement while stopped, no output expected
    cfg_enable = 1; cfg_dval_use = 1;
    frame(6, 3, 0, 100, -1, "R3");

    pulse();
    frame(8, 4, 0, 60, -1, "R1");
    check("R1", "qualified width", stat_width, line_n);
    frame(5, 3, 1, 50, -1, "R5");
    frame(1, 1, 1, 100, -1, "R5");

    cfg_dval_use = 0;
    frame(7, 3, 0, 30, -1, "R2");
    check("R2", "width ignores data-valid", stat_width, 7);
    frame(4, 2, 1, 0, -1, "R11");

    // stop inside a captured frame, then one frame idle
    cfg_dval_use = 1;
    frame(6, 3, 0, 80, 5, "R4");
    frame(6, 3, 0, 80, -1, "R4");
    // start inside a frame: that frame skipped, next captured
    frame(6, 3, 0, 80, 4, "R3");
    frame(6, 3, 0, 80, -1, "R3");

    // disable: run cleared, start ignored, measurement continues
    cfg_enable = 0; run_m = 0;
    frame(9, 2, 0, 100, 3, "R9");
    check("R9", "width while disabled", stat_width, 9);
    cfg_enable = 1;
    frame(5, 2, 0, 100, -1, "R9");
    pulse();

    for (int i = 0; i < 30; i++) begin
      cfg_dval_use = 1'($urandom);
      frame($urandom_range(1, 12), $urandom_range(1, 5), 1'($urandom),
            $urandom_range(20, 100), -1, "R11");
    end

    check("R6", "no overflow yet", out_overflow, 0);
    out_ready = 0;
    frame(6, 3, 0, 100, -1, "R6");
    out_ready = 1;
    check("R6", "overflow set", out_overflow, 1);
    frame(4, 2, 0, 100, -1, "R6");
    check("R6", "overflow sticky", out_overflow, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule